// File: doc/BRIEF.md
# Management Command Engine (Single-Word MDIO Master)

This block turns one 32-bit memory-mapped command word into a serial management transaction toward a PHY register. Software places the operation code, the 5-bit device address, the 5-bit register address and, for a write, 16 bits of write data into a single register write. That write launches a clause-22 style MDIO frame on the MDC/MDIO pins. Software then polls a completion flag in the same word. After a read, it takes the returned 16 bits from the upper half of that word.

A separate one-bit test-control register gates management access. The command word answers only to bus port 0. MDC is generated from the system clock by a clock-enable divider. A read-modify-write is a read command, a poll for completion, and then a write command carrying the modified upper half. All control and status pins are plain level or pulse signals. The block has no streaming data path, so it uses no valid/ready handshake and applies no back-pressure: the completion flag is the only flow control.

Top module: `mgmt_cmd_engine`

## Requirements
- R1: After reset the command word reads 0x0000_8000 (only the done flag set), test-control reads 0, mdio_oe is 0 and mdc is 0.
- R2: Command word layout: bits 31:16 hold write data or returned read data, bit 15 is done, bits 14:13 are the operation (2'b10 read, 2'b01 write), bits 12:8 the device address, bits 4:0 the register address; bits 7:5 always read as zero.
- R3: A write to the command word is accepted when bus_port is 0, bus_sel is 0, test-control bit 0 is 1 and done is 1. An accepted write with a valid operation clears done by the next cycle and sends one frame: 32 ones, start bits 0 then 1, the two operation bits, the device address MSB first, the register address MSB first, two turnaround bits, then 16 data bits MSB first. MDC has a period of 2*MDC_HALF_DIV clocks, and mdio_o changes only on a falling MDC edge.
- R4: In a write frame the block drives the turnaround as 1 then 0, followed by bits 31:16 of the command word.
- R5: In a read frame mdio_oe is 0 for the two turnaround bits and the 16 data bits. The block samples mdio_i on each rising MDC edge of the data bits, MSB first, and loads the value into bits 31:16 on the same clock edge that sets done.
- R6: Done sets between 128*MDC_HALF_DIV+1 and 130*MDC_HALF_DIV clock cycles after the clock edge that accepts the command.
- R7: A command-word write while done is 0 is ignored: the running frame and bits 14:0 of the word are unchanged.
- R8: While test-control bit 0 is 0, command-word writes leave the word unchanged with done set and start no frame. Clearing test-control during a frame does not abort that frame.
- R9: A bus_port other than 0 reads as zero and cannot write the command word.
- R10: An accepted write whose operation is 2'b00 or 2'b11 stores its fields but leaves done at 1 and starts no frame.
- R11: A read followed by a write of the modified upper half delivers the modified value to the PHY register.
- R12: Test-control can be written from any port (bus_sel 1) and keeps only bit 0; on port 0 it reads back with bits 31:1 at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_port | input | PORT_W | Port index of the access |
| bus_sel | input | 1 | 0 selects the command word, 1 selects test-control |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational read data for bus_port and bus_sel |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
Two results fall due a fixed number of cycles after a register write. The cleared done flag must be visible on the read port half a clock after the accepting edge, so the bench reads it at the falling edge right after the write. Done must set inside the window given in R6; the bench polls once per clock at the falling edge and checks that the count of clocks since acceptance falls in that window. The frame contents, the read data and the turnaround behaviour are checked at MDC edges by a PHY model that samples on rising MDC and drives on falling MDC, so each bit is compared in the MDC period in which it is due. The sweep covers all 32 device addresses for both reads and writes, and the ignored-write cases are checked by waiting longer than one frame and confirming that the frame count has not moved.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  typedef struct packed {
    logic [15:0] data;
    logic        done;
    logic [1:0]  op;
    logic [4:0]  dev;
    logic [2:0]  rsv;
    logic [4:0]  regad;
  } cmd_t;

  function automatic logic op_valid(input logic [1:0] op);
    return (op == OP_RD) || (op == OP_WR);
  endfunction
endpackage

// File: rtl/mgmt_clk_div.sv
module mgmt_clk_div #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          tick;

  assign tick      = (cnt_q == CNT_LAST);
  assign rise_tick = tick && !mdc;
  assign fall_tick = tick && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc   <= !mdc;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mgmt_frame_seq.sv
module mgmt_frame_seq
  import mgmt_pkg::*;
#(
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  op,
  input  logic [4:0]  dev,
  input  logic [4:0]  regad,
  input  logic [15:0] wdata,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        busy,
  output logic        fin,
  output logic [15:0] rdata
);
  localparam int FRAME_BITS = PRE_BITS + 32;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(PRE_BITS + 14);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(PRE_BITS + 16);

  logic [FRAME_BITS-1:0] sh_q;
  logic [IDX_W-1:0]      idx_q;
  logic [IDX_W-1:0]      idx_nx;
  logic                  started_q;
  logic                  rd_q;
  logic [15:0]           cap_q;
  logic [1:0]            ta_bits;

  assign ta_bits = (op == OP_RD) ? 2'b11 : 2'b10;
  assign idx_nx  = idx_q + 1'b1;
  assign fin     = busy && started_q && fall_tick && (idx_q == LAST_IDX);
  assign rdata   = cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '0;
      idx_q     <= '0;
      started_q <= 1'b0;
      rd_q      <= 1'b0;
      busy      <= 1'b0;
      mdio_o    <= 1'b1;
      mdio_oe   <= 1'b0;
    end else if (start) begin
      busy      <= 1'b1;
      started_q <= 1'b0;
      rd_q      <= (op == OP_RD);
      sh_q      <= {{PRE_BITS{1'b1}}, 2'b01, op, dev, regad, ta_bits, wdata};
    end else if (busy && fall_tick) begin
      if (!started_q) begin
        started_q <= 1'b1;
        idx_q     <= '0;
        mdio_o    <= sh_q[FRAME_BITS-1];
        mdio_oe   <= 1'b1;
        sh_q      <= sh_q << 1;
      end else if (idx_q == LAST_IDX) begin
        busy      <= 1'b0;
        started_q <= 1'b0;
        mdio_oe   <= 1'b0;
        mdio_o    <= 1'b1;
      end else begin
        idx_q     <= idx_nx;
        mdio_o    <= sh_q[FRAME_BITS-1];
        mdio_oe   <= !(rd_q && (idx_nx >= TA_IDX));
        sh_q      <= sh_q << 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else if (busy && started_q && rise_tick && rd_q && (idx_q >= DATA_IDX)) begin
      cap_q <= {cap_q[14:0], mdio_i};
    end
  end
endmodule

// File: rtl/mgmt_cmd_regs.sv
module mgmt_cmd_regs
  import mgmt_pkg::*;
#(
  parameter int PORT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [PORT_W-1:0] bus_port,
  input  logic              bus_sel,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              seq_fin,
  input  logic [15:0]       seq_rdata,
  output logic              start,
  output cmd_t              cmd_word,
  output logic              tctl_en
);
  cmd_t wr_cmd;
  logic cmd_wr;
  logic tctl_wr;
  logic accept;
  logic port0;

  assign wr_cmd  = cmd_t'(bus_wdata);
  assign port0   = (bus_port == '0);
  assign cmd_wr  = bus_we && port0 && !bus_sel;
  assign tctl_wr = bus_we && bus_sel;
  assign accept  = cmd_wr && tctl_en && cmd_word.done;
  assign start   = accept && op_valid(wr_cmd.op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_word <= '{data: 16'h0, done: 1'b1, op: 2'b00, dev: 5'h0, rsv: 3'h0, regad: 5'h0};
      tctl_en  <= 1'b0;
    end else begin
      if (tctl_wr) tctl_en <= bus_wdata[0];
      if (seq_fin) begin
        cmd_word.done <= 1'b1;
        if (cmd_word.op == OP_RD) cmd_word.data <= seq_rdata;
      end else if (accept) begin
        cmd_word.data  <= wr_cmd.data;
        cmd_word.done  <= !op_valid(wr_cmd.op);
        cmd_word.op    <= wr_cmd.op;
        cmd_word.dev   <= wr_cmd.dev;
        cmd_word.regad <= wr_cmd.regad;
      end
    end
  end

  always_comb begin
    if (!port0)       bus_rdata = '0;
    else if (bus_sel) bus_rdata = {31'h0, tctl_en};
    else              bus_rdata = cmd_word;
  end
endmodule

// File: rtl/mgmt_cmd_engine.sv
module mgmt_cmd_engine
  import mgmt_pkg::*;
#(
  parameter int PORT_W       = 2,
  parameter int MDC_HALF_DIV = 2,
  parameter int PRE_BITS     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [PORT_W-1:0] bus_port,
  input  logic              bus_sel,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  cmd_t        cmd_word;
  cmd_t        wcmd;
  logic        start;
  logic        tctl_en;
  logic        cmd_done;
  logic        seq_busy;
  logic        seq_fin;
  logic [15:0] seq_rdata;
  logic        rise_tick;
  logic        fall_tick;

  assign wcmd     = cmd_t'(bus_wdata);
  assign cmd_done = cmd_word.done;

  mgmt_clk_div #(.HALF_DIV(MDC_HALF_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .mdc(mdc),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mgmt_cmd_regs #(.PORT_W(PORT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_port(bus_port),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .seq_fin(seq_fin), .seq_rdata(seq_rdata), .start(start),
    .cmd_word(cmd_word), .tctl_en(tctl_en)
  );

  mgmt_frame_seq #(.PRE_BITS(PRE_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(wcmd.op), .dev(wcmd.dev),
    .regad(wcmd.regad), .wdata(wcmd.data), .rise_tick(rise_tick),
    .fall_tick(fall_tick), .mdio_i(mdio_i), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .busy(seq_busy), .fin(seq_fin), .rdata(seq_rdata)
  );
endmodule

// File: rtl/mgmt_cmd_engine_chk.sv
module mgmt_cmd_engine_chk #(
  parameter int PORT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [PORT_W-1:0] bus_port,
  input logic              bus_sel,
  input logic [31:0]       bus_rdata,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic              cmd_done,
  input logic              tctl_en,
  input logic [31:0]       cmd_bits
);
  AST_DONE_FALLS_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_done) |-> $past(bus_we && (bus_port == '0) && !bus_sel && tctl_en)); // R3

  AST_IDLE_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> !mdio_oe); // R5

  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> $fell(mdc)); // R3

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_done && bus_we && (bus_port == '0) && !bus_sel) |=> (cmd_bits[14:0] == $past(cmd_bits[14:0]))); // R7

  AST_DISABLED_KEEPS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && !tctl_en) |=> cmd_done); // R8

  AST_FOREIGN_PORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_port != '0) |-> (bus_rdata == 32'h0)); // R9

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_port == '0) && !bus_sel) |-> (bus_rdata[7:5] == 3'h0)); // R2

  AST_TCTL_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_port == '0) && bus_sel) |-> (bus_rdata[31:1] == 31'h0)); // R12
endmodule

bind mgmt_cmd_engine mgmt_cmd_engine_chk #(.PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_port(bus_port),
  .bus_sel(bus_sel), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .cmd_done(cmd_done), .tctl_en(tctl_en),
  .cmd_bits(cmd_word)
);

// File: tb/mgmt_cmd_engine_tb.sv
`timescale 1ns/1ps
module mgmt_cmd_engine_tb;
  localparam int HALF = 2;
  localparam int PW   = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [PW-1:0] bus_port = '0;
  logic          bus_sel = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          mdc, mdio_o, mdio_oe;
  logic          mdio_i = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = !clk;

  mgmt_cmd_engine #(.PORT_W(PW), .MDC_HALF_DIV(HALF), .PRE_BITS(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_port(bus_port),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // ---------------- PHY model ----------------
  int          ph_phase = 0;
  int          ph_ones = 0;
  int          ph_cnt = 0;
  int          ph_frames = 0;
  int          ph_oe_err = 0;
  logic [11:0] ph_hdr;
  logic [17:0] ph_tail;
  logic [1:0]  ph_op;
  logic [4:0]  ph_dev, ph_reg;
  logic [1:0]  ph_ta;
  logic [15:0] ph_wd;
  logic [15:0] ph_rv;

  function automatic logic [15:0] phy_val(input logic [4:0] d, input logic [4:0] r);
    return {d, 6'h2B, r} ^ 16'hC3A5;
  endfunction

  always @(posedge mdc or negedge mdc) begin
    if (mdc) begin
      case (ph_phase)
        0: if (mdio_oe) begin
             if (mdio_o) ph_ones++;
             else if (ph_ones >= 32) ph_phase = 1;
             else ph_ones = 0;
           end
        1: begin
             ph_phase = (mdio_oe && mdio_o) ? 2 : 0;
             ph_cnt = 0; ph_ones = 0;
           end
        2: begin
             ph_hdr = {ph_hdr[10:0], mdio_o};
             ph_cnt++;
             if (ph_cnt == 12) begin
               ph_op = ph_hdr[11:10]; ph_dev = ph_hdr[9:5]; ph_reg = ph_hdr[4:0];
               ph_cnt = 0;
               ph_phase = (ph_hdr[11:10] == 2'b10) ? 4 : 3;
               ph_rv = phy_val(ph_hdr[9:5], ph_hdr[4:0]);
             end
           end
        3: begin
             ph_tail = {ph_tail[16:0], mdio_o};
             ph_cnt++;
             if (ph_cnt == 18) begin
               ph_ta = ph_tail[17:16]; ph_wd = ph_tail[15:0];
               ph_frames++; ph_phase = 0; ph_ones = 0;
             end
           end
        4: if (ph_cnt >= 1 && mdio_oe) ph_oe_err++;
        default: ph_phase = 0;
      endcase
    end else if (ph_phase == 4) begin
      ph_cnt++;
      if (ph_cnt == 1) mdio_i = 1'b1;
      else if (ph_cnt == 2) mdio_i = 1'b0;
      else if (ph_cnt <= 18) mdio_i = ph_rv[18 - ph_cnt];
      else begin mdio_i = 1'b1; ph_frames++; ph_phase = 0; ph_ones = 0; end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [PW-1:0] p, input logic s, input logic [31:0] d);
    @(negedge clk);
    bus_port = p; bus_sel = s; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_port = '0; bus_sel = 1'b0;
  endtask

  task automatic bus_read(input logic [PW-1:0] p, input logic s, output logic [31:0] d);
    bus_port = p; bus_sel = s;
    #1 d = bus_rdata;
    bus_port = '0; bus_sel = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    logic [31:0] v;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      bus_read('0, 1'b0, v);
    end while (!v[15] && lat < 2000);
  endtask

  function automatic logic [31:0] mk(input logic [15:0] d, input logic [1:0] op,
                                     input logic [4:0] dv, input logic [4:0] rg);
    return {d, 1'b0, op, dv, 3'b000, rg};
  endfunction

  task automatic run_cmd(input logic [31:0] w, output logic [31:0] rb, output int lat);
    logic [31:0] v;
    bus_write('0, 1'b0, w);
    bus_read('0, 1'b0, v);
    check(v[15] == 1'b0, "R3 done cleared next cycle", v, {v[31:16], 1'b0, v[14:0]});
    wait_done(lat);
    check(lat >= 128*HALF+1 && lat <= 130*HALF, "R6 done latency", lat, 129*HALF);
    bus_read('0, 1'b0, rb);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, exp;
    int lat, fr0, t0, t1;
    logic [4:0] rg;
    logic [15:0] d;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read('0, 1'b0, v);
    check(v == 32'h0000_8000, "R1 reset command word", v, 32'h0000_8000);
    bus_read('0, 1'b1, v);
    check(v == 32'h0, "R1 reset test-control", v, 0);
    check(mdio_oe == 1'b0, "R1 mdio_oe idle", {31'h0, mdio_oe}, 0);

    // R3 MDC period
    @(posedge mdc); t0 = $time;
    @(posedge mdc); t1 = $time;
    check((t1 - t0) == 2*HALF*8, "R3 mdc period", t1 - t0, 2*HALF*8);

    // R8 disabled: write ignored
    fr0 = ph_frames;
    bus_write('0, 1'b0, mk(16'h1234, 2'b01, 5'd3, 5'd4));
    repeat (140*HALF) @(negedge clk);
    bus_read('0, 1'b0, v);
    check(v == 32'h0000_8000, "R8 write while disabled leaves word", v, 32'h0000_8000);
    check(ph_frames == fr0, "R8 no frame while disabled", ph_frames, fr0);

    // R12 test-control keeps only bit 0, writable from any port
    bus_write(2'd3, 1'b1, 32'hFFFF_FFFF);
    bus_read('0, 1'b1, v);
    check(v == 32'h1, "R12 test-control readback", v, 1);

    // R9 foreign port
    bus_read(2'd2, 1'b0, v);
    check(v == 32'h0, "R9 foreign port reads zero", v, 0);
    bus_write(2'd1, 1'b0, mk(16'hBEEF, 2'b01, 5'd7, 5'd9));
    repeat (140*HALF) @(negedge clk);
    bus_read('0, 1'b0, v);
    check(v == 32'h0000_8000, "R9 foreign port write ignored", v, 32'h0000_8000);
    check(ph_frames == fr0, "R9 no frame from foreign port", ph_frames, fr0);

    // Write sweep over all device addresses: R2 R3 R4
    for (int dv = 0; dv < 32; dv++) begin
      rg = 5'((dv*5 + 3) % 32);
      d  = 16'(dv * 16'h1357) ^ 16'h8001;
      fr0 = ph_frames;
      run_cmd(mk(d, 2'b01, 5'(dv), rg), v, lat);
      check(ph_frames == fr0 + 1, "R3 one write frame", ph_frames, fr0 + 1);
      check({ph_op, ph_dev, ph_reg} == {2'b01, 5'(dv), rg}, "R3 write header",
            {20'h0, ph_op, ph_dev, ph_reg}, {20'h0, 2'b01, 5'(dv), rg});
      check(ph_ta == 2'b10, "R4 write turnaround", ph_ta, 2'b10);
      check(ph_wd == d, "R4 write data", ph_wd, d);
      exp = {d, 1'b1, 2'b01, 5'(dv), 3'b000, rg};
      check(v == exp, "R2 word after write", v, exp);
    end

    // Read sweep: R2 R5, reserved bits set in write
    for (int dv = 0; dv < 32; dv++) begin
      rg = 5'(31 - dv);
      fr0 = ph_frames;
      run_cmd(mk(16'hFFFF, 2'b10, 5'(dv), rg) | 32'h0000_00E0, v, lat);
      check(ph_frames == fr0 + 1, "R5 one read frame", ph_frames, fr0 + 1);
      check({ph_op, ph_dev, ph_reg} == {2'b10, 5'(dv), rg}, "R3 read header",
            {20'h0, ph_op, ph_dev, ph_reg}, {20'h0, 2'b10, 5'(dv), rg});
      exp = {phy_val(5'(dv), rg), 1'b1, 2'b10, 5'(dv), 3'b000, rg};
      check(v == exp, "R5 read data in upper half and R2 reserved zero", v, exp);
    end
    check(ph_oe_err == 0, "R5 bus released in turnaround and data", ph_oe_err, 0);

    // R7 write during busy ignored
    fr0 = ph_frames;
    bus_write('0, 1'b0, mk(16'hA1A1, 2'b01, 5'd10, 5'd11));
    repeat (20) @(negedge clk);
    bus_write('0, 1'b0, mk(16'h5E5E, 2'b10, 5'd20, 5'd21));
    wait_done(lat);
    repeat (4*HALF) @(negedge clk);
    bus_read('0, 1'b0, v);
    exp = {16'hA1A1, 1'b1, 2'b01, 5'd10, 3'b000, 5'd11};
    check(v == exp, "R7 busy write leaves word", v, exp);
    check(ph_frames == fr0 + 1 && ph_wd == 16'hA1A1 && ph_dev == 5'd10,
          "R7 running frame unchanged", {ph_frames[15:0], ph_wd}, {16'(fr0 + 1), 16'hA1A1});

    // R10 invalid opcodes
    for (int k = 0; k < 2; k++) begin
      logic [1:0] bad;
      bad = (k == 0) ? 2'b00 : 2'b11;
      fr0 = ph_frames;
      bus_write('0, 1'b0, mk(16'h0F0F, bad, 5'd2, 5'd6));
      bus_read('0, 1'b0, v);
      exp = {16'h0F0F, 1'b1, bad, 5'd2, 3'b000, 5'd6};
      check(v == exp, "R10 invalid op stored with done set", v, exp);
      repeat (140*HALF) @(negedge clk);
      check(ph_frames == fr0, "R10 invalid op sends no frame", ph_frames, fr0);
    end

    // R8 disabling mid-frame does not abort
    fr0 = ph_frames;
    bus_write('0, 1'b0, mk(16'h7777, 2'b01, 5'd1, 5'd2));
    bus_write('0, 1'b1, 32'h0);
    wait_done(lat);
    check(lat <= 130*HALF, "R8 frame completes after disable", lat, 130*HALF);
    check(ph_frames == fr0 + 1 && ph_wd == 16'h7777, "R8 frame delivered after disable",
          ph_wd, 16'h7777);
    bus_write('0, 1'b1, 32'h1);

    // R11 read-modify-write
    run_cmd(mk(16'h0, 2'b10, 5'd3, 5'd4), v, lat);
    d = v[31:16] ^ 16'h00F0;
    run_cmd(mk(d, 2'b01, 5'd3, 5'd4), v, lat);
    check(ph_wd == (phy_val(5'd3, 5'd4) ^ 16'h00F0) && ph_op == 2'b01,
          "R11 modified value written", ph_wd, phy_val(5'd3, 5'd4) ^ 16'h00F0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule